// File: doc/BRIEF.md
# Contactless Tag Activation State Machine

This block follows the selection state of a passive contactless tag while the receive path hands it decoded reader frames. Each frame arrives as a one-cycle strobe with a command byte, a parameter byte and a flag from the UID comparator. The block decides whether the tag answers and which canned reply the transmit path sends: the request answer (ATQA), the first UID part or the second UID part. RF framing, CRC and bit-level collision handling live elsewhere.

The tag has two cascade levels, so after the request it needs two selects before it becomes Active. A HALT command sent to an Active tag parks it in Halt. From Halt only the wake-up command brings the tag back. A tag woken from Halt keeps that history. Any later misstep during selection then sends it back to Halt instead of Idle.

Top module: `tag_activation_fsm`

## Requirements
- R1: While rst_ni is low and after it rises, state_o is Idle (0), respond_o is 0 and reply_sel_o is none (0). The state encodings are Idle=0, Ready1=1, Ready2=2, Active=3, Halt=4. The reply encodings are none=0, ATQA=1, UID part 1=2, UID part 2=3.
- R2: The request command (26h) in Idle moves the tag to Ready1 with an ATQA reply. In Halt the request command is ignored: the state stays Halt and there is no reply.
- R3: The wake-up command (52h) in Idle or Halt moves the tag to Ready1 with an ATQA reply.
- R4: In Ready1, command 93h with a parameter other than 70h is an anticollision. The tag stays in Ready1 and replies with UID part 1.
- R5: In Ready1, command 93h with parameter 70h and the UID-match flag set moves the tag to Ready2, with a UID part 1 reply. The same select with the match flag clear is a fallback (R8).
- R6: In Ready2, command 95h behaves the same way. An anticollision stays in Ready2 and replies with UID part 2. A matching select (parameter 70h) moves the tag to Active, with a UID part 2 reply. A non-matching select falls back (R8).
- R7: The HALT command (50h) in Active moves the tag to Halt with no reply.
- R8: Any other command in Ready1 or Ready2 is unaccepted. In Active, the activation commands 26h, 52h, 93h and 95h are unaccepted. An unaccepted command sends the tag to Halt if it was last woken from Halt, otherwise to Idle, with no reply.
- R9: In Idle or Halt, a command that the state does not accept leaves the state unchanged and produces no reply.
- R10: In Active, a command byte outside 26h, 52h, 93h, 95h and 50h leaves the tag Active with no reply.
- R11: In a cycle without a frame strobe, the state holds and respond_o is low in the following cycle.
- R12: respond_o is high exactly when reply_sel_o is not none. Both are valid for the single cycle after the strobed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | One-cycle strobe for a decoded frame |
| cmd_i | input | 8 | Command byte of the frame |
| param_i | input | 8 | Parameter byte of the frame |
| uid_match_i | input | 1 | The frame's UID bits match this tag |
| state_o | output | 3 | Current activation state |
| respond_o | output | 1 | Tag answers the frame just received |
| reply_sel_o | output | 2 | Which reply to send |

## Verification
Every result is registered, so the state, respond_o and reply_sel_o for a frame strobed at one rising edge appear right after that edge and last one cycle. The bench drives each frame on a falling edge and drops the strobe just after the next rising edge. It compares the outputs with its own model on the falling edge that follows. Idle cycles between frames are checked the same way to confirm that the state holds and the reply stays silent. Directed sequences cover the halt-history fallback. A long seeded random run mixes all command codes, select and anticollision parameters, and match flags.

// File: rtl/tag_act_pkg.sv
package tag_act_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_REQ   = 8'h26;
  localparam logic [BYTE_W-1:0] CMD_WAKE  = 8'h52;
  localparam logic [BYTE_W-1:0] CMD_CL1   = 8'h93;
  localparam logic [BYTE_W-1:0] CMD_CL2   = 8'h95;
  localparam logic [BYTE_W-1:0] CMD_HALT  = 8'h50;
  localparam logic [BYTE_W-1:0] PARAM_SEL = 8'h70;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READY1 = 3'd1,
    ST_READY2 = 3'd2,
    ST_ACTIVE = 3'd3,
    ST_HALT   = 3'd4
  } tag_state_e;

  typedef enum logic [1:0] {
    RPL_NONE = 2'd0,
    RPL_ATQA = 2'd1,
    RPL_UID1 = 2'd2,
    RPL_UID2 = 2'd3
  } reply_e;

  typedef struct packed {
    logic req;
    logic wake;
    logic cl1;
    logic cl2;
    logic halt;
    logic sel;     // parameter byte marks a select
    logic in_set;  // any activation-layer command
  } cmd_cls_t;
endpackage

// File: rtl/tag_cmd_decode.sv
module tag_cmd_decode
  import tag_act_pkg::*;
#(
  parameter int unsigned CMD_W = BYTE_W
) (
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [CMD_W-1:0] param_i,
  output cmd_cls_t         cls_o
);
  always_comb begin
    cls_o        = '0;
    cls_o.req    = (cmd_i == CMD_REQ);
    cls_o.wake   = (cmd_i == CMD_WAKE);
    cls_o.cl1    = (cmd_i == CMD_CL1);
    cls_o.cl2    = (cmd_i == CMD_CL2);
    cls_o.halt   = (cmd_i == CMD_HALT);
    cls_o.sel    = (param_i == PARAM_SEL);
    cls_o.in_set = cls_o.req | cls_o.wake | cls_o.cl1 | cls_o.cl2 | cls_o.halt;
  end
endmodule

// File: rtl/tag_act_core.sv
module tag_act_core
  import tag_act_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  cmd_cls_t   cls_i,
  input  logic       match_i,
  output tag_state_e state_o,
  output reply_e     reply_o,
  output logic       respond_o
);
  tag_state_e state_q, state_d;
  reply_e     reply_q, reply_d;
  logic       resp_q;
  logic       halted_q, halted_d;
  tag_state_e fall_st;

  assign fall_st = halted_q ? ST_HALT : ST_IDLE;

  always_comb begin
    state_d  = state_q;
    reply_d  = RPL_NONE;
    halted_d = halted_q;
    if (valid_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (cls_i.req || cls_i.wake) begin
            state_d  = ST_READY1;
            reply_d  = RPL_ATQA;
            halted_d = 1'b0;
          end
        end
        ST_HALT: begin
          if (cls_i.wake) begin
            state_d  = ST_READY1;
            reply_d  = RPL_ATQA;
            halted_d = 1'b1;
          end
        end
        ST_READY1: begin
          if (cls_i.cl1 && !cls_i.sel) begin
            reply_d = RPL_UID1;
          end else if (cls_i.cl1 && match_i) begin
            state_d = ST_READY2;
            reply_d = RPL_UID1;
          end else begin
            state_d = fall_st;
          end
        end
        ST_READY2: begin
          if (cls_i.cl2 && !cls_i.sel) begin
            reply_d = RPL_UID2;
          end else if (cls_i.cl2 && match_i) begin
            state_d = ST_ACTIVE;
            reply_d = RPL_UID2;
          end else begin
            state_d = fall_st;
          end
        end
        ST_ACTIVE: begin
          if (cls_i.halt) begin
            state_d  = ST_HALT;
            halted_d = 1'b1;
          end else if (cls_i.in_set) begin
            state_d = fall_st;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      reply_q  <= RPL_NONE;
      resp_q   <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      reply_q  <= reply_d;
      resp_q   <= (reply_d != RPL_NONE);
      halted_q <= halted_d;
    end
  end

  assign state_o   = state_q;
  assign reply_o   = reply_q;
  assign respond_o = resp_q;

  AST_QUIET_WITHOUT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!respond_o && $stable(state_o))); // R11
  AST_REQ_IGNORED_IN_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && state_o == ST_HALT && cls_i.req) |=> (state_o == ST_HALT && !respond_o)); // R2
  AST_ATQA_LANDS_READY1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reply_o == RPL_ATQA) |-> (state_o == ST_READY1)); // R3
  AST_HALT_FROM_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && state_o == ST_ACTIVE && cls_i.halt) |=> (state_o == ST_HALT && !respond_o)); // R7
  AST_UID2_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reply_o == RPL_UID2) |-> (state_o == ST_READY2 || state_o == ST_ACTIVE)); // R6
  AST_SEL_MATCH_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && state_o == ST_READY1 && cls_i.cl1 && cls_i.sel && match_i)
      |=> (state_o == ST_READY2 && reply_o == RPL_UID1)); // R5
  AST_RESPOND_PAIRS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    respond_o == (reply_o != RPL_NONE)); // R12
  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o inside {ST_IDLE, ST_READY1, ST_READY2, ST_ACTIVE, ST_HALT}); // R1
endmodule

// File: rtl/tag_activation_fsm.sv
module tag_activation_fsm
  import tag_act_pkg::*;
#(
  parameter int unsigned CMD_W = BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_valid_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [CMD_W-1:0] param_i,
  input  logic             uid_match_i,
  output logic [2:0]       state_o,
  output logic             respond_o,
  output logic [1:0]       reply_sel_o
);
  cmd_cls_t   cls;
  tag_state_e st;
  reply_e     rpl;

  tag_cmd_decode #(.CMD_W(CMD_W)) u_dec (
    .cmd_i   (cmd_i),
    .param_i (param_i),
    .cls_o   (cls)
  );

  tag_act_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (frame_valid_i),
    .cls_i     (cls),
    .match_i   (uid_match_i),
    .state_o   (st),
    .reply_o   (rpl),
    .respond_o (respond_o)
  );

  assign state_o     = st;
  assign reply_sel_o = rpl;
endmodule

// File: tb/tag_activation_fsm_tb.sv
module tag_activation_fsm_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fv = 1'b0;
  logic [7:0] cmd = 8'h00;
  logic [7:0] prm = 8'h00;
  logic       mt = 1'b0;
  logic [2:0] st;
  logic       rsp;
  logic [1:0] sel;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  // model state
  int m_st = 0;
  bit m_halted = 1'b0;
  int e_sel = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  tag_activation_fsm u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_valid_i(fv), .cmd_i(cmd),
    .param_i(prm), .uid_match_i(mt), .state_o(st), .respond_o(rsp),
    .reply_sel_o(sel)
  );

  function automatic bit in_set(input logic [7:0] c);
    return c == 8'h26 || c == 8'h52 || c == 8'h93 || c == 8'h95 || c == 8'h50;
  endfunction

  task automatic model(input logic [7:0] c, input logic [7:0] p, input logic m);
    int fall;
    fall = m_halted ? 4 : 0;
    e_sel = 0;
    case (m_st)
      0: if (c == 8'h26 || c == 8'h52) begin
           tag = (c == 8'h26) ? "R2" : "R3";
           m_st = 1; e_sel = 1; m_halted = 0;
         end else tag = "R9";
      4: if (c == 8'h52) begin tag = "R3"; m_st = 1; e_sel = 1; m_halted = 1; end
         else tag = (c == 8'h26) ? "R2" : "R9";
      1: if (c == 8'h93 && p != 8'h70) begin tag = "R4"; e_sel = 2; end
         else if (c == 8'h93 && m) begin tag = "R5"; m_st = 2; e_sel = 2; end
         else begin tag = "R8"; m_st = fall; end
      2: if (c == 8'h95 && p != 8'h70) begin tag = "R6"; e_sel = 3; end
         else if (c == 8'h95 && m) begin tag = "R6"; m_st = 3; e_sel = 3; end
         else begin tag = "R8"; m_st = fall; end
      3: if (c == 8'h50) begin tag = "R7"; m_st = 4; m_halted = 1; end
         else if (in_set(c)) begin tag = "R8"; m_st = fall; end
         else tag = "R10";
      default: ;
    endcase
  endtask

  task automatic check_out(input string t, input int es, input int ex_sel);
    n_chk++;
    if (st !== es[2:0] || sel !== ex_sel[1:0] || rsp !== (ex_sel != 0)) begin
      n_fail++;
      $display("FAIL %s: state=%0d sel=%0d rsp=%0b expected state=%0d sel=%0d rsp=%0b",
               t, st, sel, rsp, es, ex_sel, ex_sel != 0);
    end
  endtask

  // frame strobed at one rising edge, outputs checked on the next falling edge
  task automatic frame(input logic [7:0] c, input logic [7:0] p, input logic m);
    @(negedge clk);
    fv = 1'b1; cmd = c; prm = p; mt = m;
    @(posedge clk);
    #1 fv = 1'b0;
    model(c, p, m);
    @(negedge clk);
    check_out(tag, m_st, e_sel);
  endtask

  task automatic gap();
    @(negedge clk);
    cmd = 8'($urandom); prm = 8'($urandom); mt = 1'($urandom);
    @(negedge clk);
    check_out("R11", m_st, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_out("R1", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1", 0, 0);

    // directed
    frame(8'h93, 8'h70, 1'b1);  // R9 ignored in Idle
    frame(8'h26, 8'h00, 1'b0);  // R2
    frame(8'h93, 8'h20, 1'b0);  // R4
    frame(8'h93, 8'h70, 1'b1);  // R5
    frame(8'h95, 8'h20, 1'b0);  // R6 anticollision
    frame(8'h95, 8'h70, 1'b1);  // R6 select
    frame(8'h30, 8'h04, 1'b0);  // R10
    frame(8'h50, 8'h00, 1'b0);  // R7
    gap();                      // R11
    frame(8'h26, 8'h00, 1'b0);  // R2 ignored in Halt
    frame(8'h52, 8'h00, 1'b0);  // R3 from Halt
    frame(8'h93, 8'h70, 1'b0);  // R5/R8 no match -> Halt
    frame(8'h52, 8'h00, 1'b0);  // R3
    frame(8'h93, 8'h70, 1'b1);
    frame(8'h30, 8'h00, 1'b0);  // R8 -> Halt
    frame(8'h52, 8'h00, 1'b0);
    frame(8'h93, 8'h70, 1'b1);
    frame(8'h95, 8'h70, 1'b1);
    frame(8'h26, 8'h00, 1'b0);  // R8 from Active -> Halt
    frame(8'h52, 8'h00, 1'b0);  // R3
    frame(8'h50, 8'h00, 1'b0);  // R8 HALT in Ready1
    rst_n = 1'b0;
    @(negedge clk);
    m_st = 0; m_halted = 0;
    check_out("R1", 0, 0);
    rst_n = 1'b1;
    frame(8'h52, 8'h00, 1'b0);  // R3 from Idle
    frame(8'h93, 8'h70, 1'b0);  // R8 -> Idle
    frame(8'h26, 8'h00, 1'b0);
    frame(8'h95, 8'h70, 1'b1);  // R8 wrong level -> Idle

    // random
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [7:0] c, p;
      k = $urandom_range(0, 7);
      case (k)
        0: c = 8'h26;
        1: c = 8'h52;
        2, 3: c = 8'h93;
        4: c = 8'h95;
        5: c = 8'h50;
        default: c = 8'($urandom);
      endcase
      p = ($urandom_range(0, 1) == 0) ? 8'h70 : 8'($urandom);
      frame(c, p, ($urandom_range(0, 3) != 0));
      if ($urandom_range(0, 7) == 0) gap();
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end
endmodule